// File: doc/BRIEF.md
# Quadrature position decoder

This block turns already-synchronised encoder phase and index levels into a bounded position count, a direction flag and a signed-free revolution count. It accepts either a two-phase quadrature encoder or a step/direction source. Quadrature inputs can be counted on phase A edges only or on the edges of both phases. Configuration levels and reset strobes arrive as plain ports. The block emits one-cycle event pulses that an external interrupt controller latches.

The position counts between 0 and a programmable maximum and wraps at either end. Any number of position compare channels (three by default) and one revolution compare value flag the cycle in which the counter takes a matching value. No port carries a data stream, so every pin is a plain level or pulse and there is no back-pressure. Outputs are registered. A phase or index change seen on the inputs before clock edge k is reflected in the outputs right after edge k. The first cycle after reset only records the input levels.

Top module: `quad_pos_decoder`

## Requirements
- R1: In quadrature mode (`cfg_clkdir`=0) with `cfg_x4`=1, every single-phase change moves the position by one. The step counts up when phase A leads phase B: a change of A counts up when the new A differs from the new B, and a change of B counts up when the new A equals the new B.
- R2: With `cfg_x4`=0 in quadrature mode, only phase A changes move the position. A change of phase B alone produces no count and no event.
- R3: In clock/direction mode (`cfg_clkdir`=1), each rising edge of `ph_b` is one step, up when `ph_a` is 1 and down when it is 0. Falling edges and `ph_a` changes do nothing, and no phase error is ever reported in this mode.
- R4: Counting up from a position of `max_pos` or above gives 0. Counting down from 0 gives `max_pos`.
- R5: In quadrature mode, a sample in which both phases change raises `ev_phase_err` and leaves the position, direction and `ev_enc_clk` untouched.
- R6: `direction` is 1 after reset and takes the direction of each counted step (1 = up). `ev_enc_clk` pulses for every counted step. `ev_dir_change` pulses when a counted step flips `direction`.
- R7: With `cfg_dir_inv`=1, both the count direction and the reported `direction` of every step are complemented.
- R8: A rising edge of the effective index (`idx_in` XOR `cfg_idx_inv`) pulses `ev_index`. It adds one to `index_count` when `direction` was 1 before the pulse and subtracts one otherwise, wrapping modulo 2^IDX_W. Changing `cfg_idx_inv` alone is not an edge.
- R9: `rst_strobe` bit 0 clears the position, and bit 3 clears `index_count`; both win over a coincident step or pulse. Bit 2 (velocity reset, no velocity logic here) changes neither.
- R10: `rst_strobe` bit 1 arms a one-shot clear. The next index pulse then sets the position to 0, even if a counted step falls in the same cycle. Later index pulses leave the position alone.
- R11: `ev_pos_match[i]` pulses in the cycle the position is updated to a value equal to field i of `pos_cmp_vals` (bits i*POS_W upward). A step, a clear or a wrap counts as an update; holding a value does not.
- R12: `ev_rev_match` pulses in the cycle `index_count` is updated to a value equal to `idx_cmp_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ph_a | input | 1 | Phase A, or the direction level in clock/direction mode |
| ph_b | input | 1 | Phase B, or the step clock in clock/direction mode |
| idx_in | input | 1 | Index level |
| cfg_clkdir | input | 1 | 1 = clock/direction signalling, 0 = quadrature |
| cfg_x4 | input | 1 | 1 = count edges of both phases, 0 = phase A only |
| cfg_dir_inv | input | 1 | Complement count direction and reported direction |
| cfg_idx_inv | input | 1 | Treat index as active-low |
| rst_strobe | input | 4 | bit0 clear position, bit1 clear on next index, bit2 velocity (no effect), bit3 clear index count |
| max_pos | input | POS_W | Largest position value |
| pos_cmp_vals | input | NUM_CMP*POS_W | Position compare values, channel i in field i |
| idx_cmp_val | input | IDX_W | Revolution compare value |
| position | output | POS_W | Position count |
| direction | output | 1 | Direction of the last counted step, 1 = up |
| index_count | output | IDX_W | Revolution count |
| ev_index | output | 1 | Index pulse seen |
| ev_dir_change | output | 1 | Direction flipped |
| ev_phase_err | output | 1 | Both phases changed in one sample |
| ev_enc_clk | output | 1 | A step was counted |
| ev_pos_match | output | NUM_CMP | Position compare hit per channel |
| ev_rev_match | output | 1 | Revolution compare hit |

## Verification
An armed clear-on-index and a counted encoder step can land in the same cycle. Both then try to load the position register. The bench arms the clear and drives a phase A edge and the index edge in one sample. It expects position 0 with `ev_index`, `ev_enc_clk` and the channel matching 0 all pulsing together. A second index pulse must then leave the position alone. The vector table also stacks a wrap with a compare hit and a direction flip in one cycle, so the counter, direction and compare paths are judged on the same edge.

// File: rtl/qpd_pkg.sv
package qpd_pkg;
  // Bit positions inside rst_strobe; software decodes them in this order.
  localparam int RS_POS_NOW = 0;
  localparam int RS_POS_ON_IDX = 1;
  localparam int RS_VELOCITY = 2;
  localparam int RS_IDX_CNT = 3;
  localparam int RS_W = 4;

  typedef struct packed {
    logic count; // a step is taken this cycle
    logic up;    // raw sense of the step before inversion
    logic err;   // both phases moved in one sample
  } qpd_step_t;
endpackage

// File: rtl/qpd_step_decode.sv
module qpd_step_decode
  import qpd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ph_a,
  input  logic      ph_b,
  input  logic      mode_clkdir,
  input  logic      cap_x4,
  output qpd_step_t step
);
  logic a_q, b_q, primed_q;
  logic a_chg, b_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q      <= 1'b0;
      b_q      <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      a_q      <= ph_a;
      b_q      <= ph_b;
      primed_q <= 1'b1;
    end
  end

  assign a_chg = ph_a ^ a_q;
  assign b_chg = ph_b ^ b_q;

  always_comb begin
    step = '0;
    if (primed_q) begin
      if (mode_clkdir) begin
        if (ph_b && !b_q) begin
          step.count = 1'b1;
          step.up    = ph_a;
        end
      end else if (a_chg && b_chg) begin
        step.err = 1'b1;
      end else if (a_chg) begin
        step.count = 1'b1;
        step.up    = ph_a ^ ph_b;
      end else if (b_chg && cap_x4) begin
        step.count = 1'b1;
        step.up    = ~(ph_a ^ ph_b);
      end
    end
  end
endmodule

// File: rtl/qpd_wrap_counter.sv
module qpd_wrap_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic         up,
  input  logic [W-1:0] limit,
  output logic [W-1:0] value,
  output logic [W-1:0] next_value,
  output logic         update
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    next_value = value;
    if (clr) begin
      next_value = '0;
    end else if (step) begin
      if (up) next_value = (value >= limit) ? '0 : value + ONE;
      else    next_value = (value == '0) ? limit : value - ONE;
    end
  end

  assign update = clr | step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= '0;
    else        value <= next_value;
  end
endmodule

// File: rtl/qpd_match.sv
module qpd_match #(
  parameter int W = 16,
  parameter int N = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           upd,
  input  logic [W-1:0]   val,
  input  logic [N*W-1:0] refs,
  output logic [N-1:0]   hit
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit[i] <= 1'b0;
      else        hit[i] <= upd && (val == refs[i*W +: W]);
    end
  end
endmodule

// File: rtl/quad_pos_decoder.sv
module quad_pos_decoder
  import qpd_pkg::*;
#(
  parameter int POS_W   = 16,
  parameter int IDX_W   = 16,
  parameter int NUM_CMP = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ph_a,
  input  logic                     ph_b,
  input  logic                     idx_in,
  input  logic                     cfg_clkdir,
  input  logic                     cfg_x4,
  input  logic                     cfg_dir_inv,
  input  logic                     cfg_idx_inv,
  input  logic [RS_W-1:0]          rst_strobe,
  input  logic [POS_W-1:0]         max_pos,
  input  logic [NUM_CMP*POS_W-1:0] pos_cmp_vals,
  input  logic [IDX_W-1:0]         idx_cmp_val,
  output logic [POS_W-1:0]         position,
  output logic                     direction,
  output logic [IDX_W-1:0]         index_count,
  output logic                     ev_index,
  output logic                     ev_dir_change,
  output logic                     ev_phase_err,
  output logic                     ev_enc_clk,
  output logic [NUM_CMP-1:0]       ev_pos_match,
  output logic                     ev_rev_match
);
  localparam logic [IDX_W-1:0] IDX_LIMIT = '1;

  qpd_step_t        st;
  logic             cnt_up;
  logic             dir_q;
  logic             idx_raw_q, idx_primed_q, idx_rise;
  logic             arm_q;
  logic             pos_clr, idx_clr;
  logic [POS_W-1:0] pos_next;
  logic             pos_upd;
  logic [IDX_W-1:0] idx_next;
  logic             idx_upd;
  logic [0:0]       rev_hit;

  qpd_step_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .ph_a       (ph_a),
    .ph_b       (ph_b),
    .mode_clkdir(cfg_clkdir),
    .cap_x4     (cfg_x4),
    .step       (st)
  );

  assign cnt_up = st.up ^ cfg_dir_inv;

  // Index edge is judged on raw levels seen through the same polarity,
  // so flipping the polarity setting alone never looks like an edge.
  assign idx_rise = idx_primed_q &
                    (idx_in ^ cfg_idx_inv) & ~(idx_raw_q ^ cfg_idx_inv);

  assign pos_clr = rst_strobe[RS_POS_NOW] | (idx_rise & arm_q);
  assign idx_clr = rst_strobe[RS_IDX_CNT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_raw_q    <= 1'b0;
      idx_primed_q <= 1'b0;
      arm_q        <= 1'b0;
      dir_q        <= 1'b1;
      ev_index     <= 1'b0;
      ev_dir_change<= 1'b0;
      ev_phase_err <= 1'b0;
      ev_enc_clk   <= 1'b0;
    end else begin
      idx_raw_q     <= idx_in;
      idx_primed_q  <= 1'b1;
      arm_q         <= rst_strobe[RS_POS_ON_IDX] | (arm_q & ~idx_rise);
      if (st.count) dir_q <= cnt_up;
      ev_index      <= idx_rise;
      ev_dir_change <= st.count && (cnt_up != dir_q);
      ev_phase_err  <= st.err;
      ev_enc_clk    <= st.count;
    end
  end

  qpd_wrap_counter #(.W(POS_W)) u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (pos_clr),
    .step      (st.count),
    .up        (cnt_up),
    .limit     (max_pos),
    .value     (position),
    .next_value(pos_next),
    .update    (pos_upd)
  );

  qpd_wrap_counter #(.W(IDX_W)) u_idx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (idx_clr),
    .step      (idx_rise),
    .up        (dir_q),
    .limit     (IDX_LIMIT),
    .value     (index_count),
    .next_value(idx_next),
    .update    (idx_upd)
  );

  qpd_match #(.W(POS_W), .N(NUM_CMP)) u_pos_cmp (
    .clk  (clk),
    .rst_n(rst_n),
    .upd  (pos_upd),
    .val  (pos_next),
    .refs (pos_cmp_vals),
    .hit  (ev_pos_match)
  );

  qpd_match #(.W(IDX_W), .N(1)) u_rev_cmp (
    .clk  (clk),
    .rst_n(rst_n),
    .upd  (idx_upd),
    .val  (idx_next),
    .refs (idx_cmp_val),
    .hit  (rev_hit)
  );

  assign ev_rev_match = rev_hit[0];
  assign direction    = dir_q;
endmodule

// File: rtl/qpd_checker.sv
module qpd_checker #(
  parameter int POS_W = 16,
  parameter int IDX_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       rst_strobe,
  input logic [POS_W-1:0] max_pos,
  input logic             cfg_clkdir,
  input logic [POS_W-1:0] position,
  input logic             direction,
  input logic [IDX_W-1:0] index_count,
  input logic             ev_index,
  input logic             ev_dir_change,
  input logic             ev_phase_err,
  input logic             ev_enc_clk,
  input logic             pos_clr
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_err_no_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_phase_err |-> !ev_enc_clk);

  assert_err_holds_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ev_phase_err && !$past(pos_clr)) |-> $stable(position));

  assert_clkdir_no_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cfg_clkdir)) |-> !ev_phase_err);

  assert_pos_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ($past(position) <= $past(max_pos))) |-> (position <= $past(max_pos)));

  assert_dir_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ev_dir_change) |-> (direction != $past(direction)));

  assert_idx_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !ev_index && !$past(rst_strobe[3])) |-> $stable(index_count));

  assert_pos_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_strobe[0] |=> (position == '0));

  assert_idx_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_strobe[3] |=> (index_count == '0));

  assert_vel_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ($past(rst_strobe) == 4'b0100) && !ev_enc_clk && !ev_index)
      |-> ($stable(position) && $stable(index_count)));
endmodule

bind quad_pos_decoder qpd_checker #(.POS_W(POS_W), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rst_strobe   (rst_strobe),
  .max_pos      (max_pos),
  .cfg_clkdir   (cfg_clkdir),
  .position     (position),
  .direction    (direction),
  .index_count  (index_count),
  .ev_index     (ev_index),
  .ev_dir_change(ev_dir_change),
  .ev_phase_err (ev_phase_err),
  .ev_enc_clk   (ev_enc_clk),
  .pos_clr      (pos_clr)
);

// File: tb/quad_pos_decoder_tb.sv
`timescale 1ns/1ps
module quad_pos_decoder_tb;
  typedef struct packed {
    logic [15:0] pos;
    logic        dir;
    logic [15:0] idxc;
    logic [3:0]  ev;   // {index, dir change, phase error, enc clk}
    logic [2:0]  pm;
    logic        rev;
  } obs_t;

  typedef struct packed {
    logic       a;
    logic       b;
    logic       i;
    logic [3:0] strb;
    logic       clkdir;
    logic       x4;
    logic       dinv;
    logic       iinv;
    obs_t       exp;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{1,0,0,4'h0, 0,1,0,0, '{16'd1,1,16'd0,4'b0001,3'b000,0}},
    '{1,1,0,4'h0, 0,1,0,0, '{16'd2,1,16'd0,4'b0001,3'b001,0}},
    '{0,1,0,4'h0, 0,1,0,0, '{16'd3,1,16'd0,4'b0001,3'b000,0}},
    '{0,0,0,4'h0, 0,1,0,0, '{16'd4,1,16'd0,4'b0001,3'b000,0}},
    '{1,0,0,4'h0, 0,1,0,0, '{16'd5,1,16'd0,4'b0001,3'b010,0}},
    '{1,1,0,4'h0, 0,1,0,0, '{16'd0,1,16'd0,4'b0001,3'b100,0}},
    '{1,1,0,4'h0, 0,1,0,0, '{16'd0,1,16'd0,4'b0000,3'b000,0}},
    '{1,0,0,4'h0, 0,1,0,0, '{16'd5,0,16'd0,4'b0101,3'b010,0}},
    '{0,0,0,4'h0, 0,1,0,0, '{16'd4,0,16'd0,4'b0001,3'b000,0}},
    '{1,1,0,4'h0, 0,1,0,0, '{16'd4,0,16'd0,4'b0010,3'b000,0}},
    '{0,0,0,4'h0, 0,1,0,0, '{16'd4,0,16'd0,4'b0010,3'b000,0}},
    '{0,0,1,4'h0, 0,1,0,0, '{16'd4,0,16'hFFFF,4'b1000,3'b000,0}},
    '{0,0,0,4'h0, 0,1,0,0, '{16'd4,0,16'hFFFF,4'b0000,3'b000,0}},
    '{0,1,0,4'h0, 0,0,0,0, '{16'd4,0,16'hFFFF,4'b0000,3'b000,0}},
    '{1,1,0,4'h0, 0,0,0,0, '{16'd3,0,16'hFFFF,4'b0001,3'b000,0}},
    '{1,0,0,4'h0, 0,0,0,0, '{16'd3,0,16'hFFFF,4'b0000,3'b000,0}},
    '{0,0,0,4'h0, 0,0,0,0, '{16'd2,0,16'hFFFF,4'b0001,3'b001,0}},
    '{1,0,0,4'h0, 0,0,0,0, '{16'd3,1,16'hFFFF,4'b0101,3'b000,0}},
    '{1,0,1,4'h0, 0,0,0,0, '{16'd3,1,16'd0,4'b1000,3'b000,0}},
    '{1,0,0,4'h0, 0,0,0,0, '{16'd3,1,16'd0,4'b0000,3'b000,0}},
    '{1,0,1,4'h0, 0,0,0,0, '{16'd3,1,16'd1,4'b1000,3'b000,0}},
    '{1,0,0,4'h0, 0,0,0,0, '{16'd3,1,16'd1,4'b0000,3'b000,0}},
    '{1,0,1,4'h0, 0,0,0,0, '{16'd3,1,16'd2,4'b1000,3'b000,1}},
    '{1,0,0,4'h0, 0,0,0,0, '{16'd3,1,16'd2,4'b0000,3'b000,0}},
    '{1,1,0,4'h0, 0,1,1,0, '{16'd2,0,16'd2,4'b0101,3'b001,0}},
    '{0,1,0,4'h0, 0,1,1,0, '{16'd1,0,16'd2,4'b0001,3'b000,0}},
    '{0,0,0,4'h0, 0,1,0,0, '{16'd2,1,16'd2,4'b0101,3'b001,0}},
    '{0,0,0,4'h4, 0,1,0,0, '{16'd2,1,16'd2,4'b0000,3'b000,0}},
    '{0,0,0,4'h8, 0,1,0,0, '{16'd2,1,16'd0,4'b0000,3'b000,0}},
    '{0,0,0,4'h1, 0,1,0,0, '{16'd0,1,16'd2 - 16'd2,4'b0000,3'b100,0}}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ph_a = 1'b0, ph_b = 1'b0, idx_in = 1'b0;
  logic        cfg_clkdir = 1'b0, cfg_x4 = 1'b1, cfg_dir_inv = 1'b0, cfg_idx_inv = 1'b0;
  logic [3:0]  rst_strobe = 4'h0;
  logic [15:0] max_pos = 16'd5;
  logic [47:0] pos_cmp_vals = {16'd0, 16'd5, 16'd2};
  logic [15:0] idx_cmp_val = 16'd2;
  logic [15:0] position, index_count;
  logic        direction, ev_index, ev_dir_change, ev_phase_err, ev_enc_clk, ev_rev_match;
  logic [2:0]  ev_pos_match;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  quad_pos_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .ph_a(ph_a), .ph_b(ph_b), .idx_in(idx_in),
    .cfg_clkdir(cfg_clkdir), .cfg_x4(cfg_x4), .cfg_dir_inv(cfg_dir_inv),
    .cfg_idx_inv(cfg_idx_inv), .rst_strobe(rst_strobe), .max_pos(max_pos),
    .pos_cmp_vals(pos_cmp_vals), .idx_cmp_val(idx_cmp_val),
    .position(position), .direction(direction), .index_count(index_count),
    .ev_index(ev_index), .ev_dir_change(ev_dir_change), .ev_phase_err(ev_phase_err),
    .ev_enc_clk(ev_enc_clk), .ev_pos_match(ev_pos_match), .ev_rev_match(ev_rev_match)
  );

  function automatic string row_tag(int r);
    if (r < 6)       return "R1 R4 R11";
    else if (r < 9)  return "R4 R6";
    else if (r < 11) return "R5";
    else if (r < 13) return "R8";
    else if (r < 18) return "R2 R6";
    else if (r < 24) return "R8 R12";
    else if (r < 27) return "R7";
    else             return "R9 R11";
  endfunction

  task automatic check_obs(string tag, obs_t exp);
    obs_t act;
    act = '{position, direction, index_count,
            {ev_index, ev_dir_change, ev_phase_err, ev_enc_clk},
            ev_pos_match, ev_rev_match};
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual pos=%0d dir=%0d idx=%h ev=%b pm=%b rev=%0d, expected pos=%0d dir=%0d idx=%h ev=%b pm=%b rev=%0d",
               tag, act.pos, act.dir, act.idxc, act.ev, act.pm, act.rev,
               exp.pos, exp.dir, exp.idxc, exp.ev, exp.pm, exp.rev);
    end
  endtask

  task automatic drive(logic a, logic b, logic i, logic [3:0] s);
    ph_a = a; ph_b = b; idx_in = i; rst_strobe = s;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual running, expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_obs("R6 reset state held", '{16'd0, 1'b1, 16'd0, 4'b0000, 3'b000, 1'b0});
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_obs("R6 after reset release", '{16'd0, 1'b1, 16'd0, 4'b0000, 3'b000, 1'b0});

    for (int r = 0; r < NV; r++) begin
      ph_a = VEC[r].a; ph_b = VEC[r].b; idx_in = VEC[r].i; rst_strobe = VEC[r].strb;
      cfg_clkdir = VEC[r].clkdir; cfg_x4 = VEC[r].x4;
      cfg_dir_inv = VEC[r].dinv; cfg_idx_inv = VEC[r].iinv;
      @(negedge clk);
      check_obs($sformatf("row %0d %s", r, row_tag(r)), VEC[r].exp);
    end
    rst_strobe = 4'h0;

    // R3 clock/direction: both pins change, B rises with A high -> up, no error
    cfg_clkdir = 1'b1;
    drive(1, 1, 0, 4'h0);
    check_obs("R3 rise with A high", '{16'd1, 1'b1, 16'd0, 4'b0001, 3'b000, 1'b0});
    drive(1, 0, 0, 4'h0);
    check_obs("R3 falling B ignored", '{16'd1, 1'b1, 16'd0, 4'b0000, 3'b000, 1'b0});
    drive(0, 1, 0, 4'h0);
    check_obs("R3 rise with A low", '{16'd0, 1'b0, 16'd0, 4'b0101, 3'b100, 1'b0});
    drive(0, 0, 0, 4'h0);
    check_obs("R3 idle", '{16'd0, 1'b0, 16'd0, 4'b0000, 3'b000, 1'b0});
    cfg_clkdir = 1'b0;
    @(negedge clk);

    // R8 inverted index: polarity flip alone is not an edge
    cfg_idx_inv = 1'b1;
    @(negedge clk);
    check_obs("R8 polarity flip only", '{16'd0, 1'b0, 16'd0, 4'b0000, 3'b000, 1'b0});
    drive(0, 0, 1, 4'h0);
    check_obs("R8 inactive level", '{16'd0, 1'b0, 16'd0, 4'b0000, 3'b000, 1'b0});
    drive(0, 0, 0, 4'h0);
    check_obs("R8 active-low pulse", '{16'd0, 1'b0, 16'hFFFF, 4'b1000, 3'b000, 1'b0});
    drive(0, 0, 1, 4'h0);
    cfg_idx_inv = 1'b0;
    drive(0, 0, 0, 4'h0);

    // R10 armed clear coinciding with a counted step
    drive(0, 0, 0, 4'h2);
    check_obs("R10 arming leaves position", '{16'd0, 1'b0, 16'hFFFF, 4'b0000, 3'b000, 1'b0});
    drive(1, 0, 1, 4'h0);
    check_obs("R10 clear beats step", '{16'd0, 1'b1, 16'hFFFE, 4'b1101, 3'b100, 1'b0});
    drive(1, 0, 0, 4'h0);
    drive(1, 1, 0, 4'h0);
    check_obs("R10 counting resumes", '{16'd1, 1'b1, 16'hFFFE, 4'b0001, 3'b000, 1'b0});
    drive(1, 1, 1, 4'h0);
    check_obs("R10 one-shot", '{16'd1, 1'b1, 16'hFFFF, 4'b1000, 3'b000, 1'b0});
    drive(1, 1, 0, 4'h0);

    // R4 wrap down to a changed maximum
    max_pos = 16'd9;
    drive(1, 1, 0, 4'h1);
    drive(1, 0, 0, 4'h0);
    check_obs("R4 down from zero to new max", '{16'd9, 1'b0, 16'hFFFF, 4'b0101, 3'b000, 1'b0});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule